// File: doc/BRIEF.md
# Coalescing Write Buffer

This block is a short store queue placed between a cache controller and main memory. It takes two kinds of input: single-word stores with byte strobes, and whole dirty lines evicted from the cache. Each accepted item sits in a line-sized slot, with a block address aligned to the line, the line's data and one valid bit per byte. Slots go out to a simple memory write port strictly in the order they were allocated. Only the bytes marked valid are enabled on that port. The core can never read back data held here.

A store to a block that already has a waiting slot is folded into that slot and takes no new one. Later bytes overwrite earlier bytes. The slot at the head of the queue is the one being offered to memory, and it takes no more merges. A same-block store that arrives while its block is at the head therefore opens a fresh slot. When every slot is taken, the input is refused unless the store can merge. A drain request stops new input and holds the quiesced flag low until every slot has been written out.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `in_ready` is 1, `mem_valid` is 0 and `quiesced` is 1.
- R2: A word store (`in_line`=0) opens a slot whose `mem_addr` is `in_addr` with its low 5 bits cleared. The word index is `in_addr[4:2]`. The store's data appears in bits [32*w+31:32*w] of `mem_data`, and `mem_be` is `in_strb` shifted left by 4*w. Byte enable bit k covers `mem_data` bits [8k+7:8k].
- R3: A line input (`in_line`=1) opens a slot with all 32 byte enables set and `mem_data` equal to `in_line_data`.
- R4: An input whose block matches a waiting slot that is not the head slot is merged into that slot and uses no new slot. Enables are ORed together, and bytes enabled by the newer input replace the older bytes.
- R5: The head slot, which is offered to memory, accepts no merge. A same-block input meanwhile opens a new slot and is written out separately, after the head.
- R6: Slots are written to memory in the order they were allocated.
- R7: With all DEPTH slots in use, `full` is 1. In that state `in_ready` is 0 for an input that cannot merge and 1 for an input that can.
- R8: After a `drain_req` pulse, `in_ready` is 0 and `quiesced` is 0 until every slot has been written. `quiesced` returns to 1 one cycle after the buffer becomes empty.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, the memory port's address, data and enables stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item present |
| in_line | input | 1 | 1: whole evicted line, 0: word store |
| in_addr | input | 32 | Byte address of the item |
| in_word | input | 32 | Word store data |
| in_strb | input | 4 | Word store byte strobes |
| in_line_data | input | 256 | Whole line data |
| in_ready | output | 1 | Item accepted on this edge when in_valid is 1 |
| drain_req | input | 1 | Pulse: write out everything and block input until done |
| quiesced | output | 1 | No drain outstanding and buffer empty |
| full | output | 1 | All slots in use |
| empty | output | 1 | No slot in use |
| mem_valid | output | 1 | Memory write offered |
| mem_addr | output | 32 | Line-aligned write address |
| mem_data | output | 256 | Line write data |
| mem_be | output | 32 | Per-byte write enables |
| mem_ready | input | 1 | Memory takes the write on this edge |

## Verification
The hardest cases to reach are the ones where the merge decision meets a busy queue. One is a merge into a full buffer. The other is a same-block store that arrives while its block is the head being offered to memory. The bench holds `mem_ready` low to freeze the head and fills the slots with distinct blocks. It then offers candidate inputs without letting an edge accept them, and reads `in_ready` for a mergeable block, a new block and the head's block. Merge results are then confirmed from the byte enables and data logged at the memory port.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int BPW        = WORD_W / 8;
    localparam int LINE_BYTES = BPW * LINE_WORDS;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int BSEL_W     = $clog2(BPW);
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = BSEL_W + WSEL_W;
    localparam int BLK_W      = ADDR_W - OFF_W;
    localparam int WA_W       = ADDR_W - BSEL_W;

    typedef struct packed {
        logic [BLK_W-1:0]      blk;
        logic [LINE_W-1:0]     data;
        logic [LINE_BYTES-1:0] mask;
    } wb_entry_t;

    // Turn one input item into a line-shaped slot image.
    function automatic wb_entry_t make_req(
        input logic              is_line,
        input logic [WA_W-1:0]   waddr,
        input logic [WORD_W-1:0] word,
        input logic [BPW-1:0]    strb,
        input logic [LINE_W-1:0] line
    );
        wb_entry_t e;
        logic [WSEL_W-1:0] w;
        w     = waddr[WSEL_W-1:0];
        e.blk = waddr[WA_W-1:WSEL_W];
        if (is_line) begin
            e.data = line;
            e.mask = '1;
        end else begin
            e.data = {LINE_WORDS{word}};
            e.mask = LINE_BYTES'(strb) << (int'(w) * BPW);
        end
        return e;
    endfunction

    // Newer bytes overwrite older ones; masks accumulate.
    function automatic wb_entry_t merge_entry(input wb_entry_t old_e, input wb_entry_t new_e);
        wb_entry_t r;
        r = old_e;
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (new_e.mask[b]) r.data[8*b +: 8] = new_e.data[8*b +: 8];
        end
        r.mask = old_e.mask | new_e.mask;
        return r;
    endfunction
endpackage

// File: rtl/cwb_ring_ptr.sv
module cwb_ring_ptr #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/cwb_match.sv
module cwb_match
    import cwb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0][BLK_W-1:0] slot_blk,
    input  logic [DEPTH-1:0]            slot_open,
    input  logic [BLK_W-1:0]            req_blk,
    output logic                        hit,
    output logic [PTR_W-1:0]            hit_idx
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = slot_open[i] && (slot_blk[i] == req_blk);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = PTR_W'(i);
        end
    end
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf
    import cwb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_line,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [WORD_W-1:0]     in_word,
    input  logic [BPW-1:0]        in_strb,
    input  logic [LINE_W-1:0]     in_line_data,
    output logic                  in_ready,
    input  logic                  drain_req,
    output logic                  quiesced,
    output logic                  full,
    output logic                  empty,
    output logic                  mem_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_data,
    output logic [LINE_BYTES-1:0] mem_be,
    input  logic                  mem_ready
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    wb_entry_t                  slot_q [DEPTH];
    logic [DEPTH-1:0]           occ_q;
    logic [DEPTH-1:0][BLK_W-1:0] slot_blk;
    logic [DEPTH-1:0]           slot_open;
    logic [PTR_W-1:0]           rd_ptr, wr_ptr, hit_idx;
    logic                       hit, pop, alloc, mrg, drain_pend;
    wb_entry_t                  req;
    logic                       unused_low;

    assign unused_low = ^in_addr[BSEL_W-1:0];
    assign req = make_req(in_line, in_addr[ADDR_W-1:BSEL_W], in_word, in_strb, in_line_data);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign slot_blk[i]  = slot_q[i].blk;
        assign slot_open[i] = occ_q[i] && (PTR_W'(i) != rd_ptr);
    end

    cwb_match #(.DEPTH(DEPTH)) u_match (
        .slot_blk (slot_blk),
        .slot_open(slot_open),
        .req_blk  (req.blk),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    assign empty     = ~|occ_q;
    assign full      = &occ_q;
    assign in_ready  = !drain_pend && (hit || !full);
    assign alloc     = in_valid && in_ready && !hit;
    assign mrg       = in_valid && in_ready && hit;
    assign mem_valid = occ_q[rd_ptr];
    assign pop       = mem_valid && mem_ready;
    assign mem_addr  = {slot_q[rd_ptr].blk, {OFF_W{1'b0}}};
    assign mem_data  = slot_q[rd_ptr].data;
    assign mem_be    = slot_q[rd_ptr].mask;
    assign quiesced  = !drain_pend && empty;

    cwb_ring_ptr #(.DEPTH(DEPTH)) u_wr (.clk(clk), .rst(rst), .step(alloc), .ptr(wr_ptr));
    cwb_ring_ptr #(.DEPTH(DEPTH)) u_rd (.clk(clk), .rst(rst), .step(pop),   .ptr(rd_ptr));

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q      <= '0;
            drain_pend <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc && wr_ptr == PTR_W'(i)) occ_q[i] <= 1'b1;
                else if (pop && rd_ptr == PTR_W'(i)) occ_q[i] <= 1'b0;
            end
            drain_pend <= drain_req || (drain_pend && !empty);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) slot_q[wr_ptr] <= req;
        if (mrg)   slot_q[hit_idx] <= merge_entry(slot_q[hit_idx], req);
    end
endmodule

// File: rtl/cwb_chk.sv
module cwb_chk
    import cwb_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  full,
    input logic                  empty,
    input logic                  quiesced,
    input logic                  drain_pend,
    input logic                  mem_valid,
    input logic                  mem_ready,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [LINE_W-1:0]     mem_data,
    input logic [LINE_BYTES-1:0] mem_be
);
    // R1
    empty_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !mem_valid);

    // R7
    full_merge_only_chk: assert property (@(posedge clk) disable iff (rst)
        (full && in_valid && in_ready && !(mem_valid && mem_ready)) |=> full);

    // R8
    drain_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        drain_pend |-> !in_ready);

    // R8
    quiesced_empty_chk: assert property (@(posedge clk) disable iff (rst)
        quiesced |-> (empty && !mem_valid));

    // R9
    hold_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));
endmodule

bind coalesce_wbuf cwb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .full      (full),
    .empty     (empty),
    .quiesced  (quiesced),
    .drain_pend(drain_pend),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_be    (mem_be)
);

// File: tb/coalesce_wbuf_test.sv
`timescale 1ns/1ps
module coalesce_wbuf_test;
    import cwb_pkg::*;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_line = 0, drain_req = 0, mem_ready = 0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [WORD_W-1:0] in_word = '0;
    logic [BPW-1:0] in_strb = '0;
    logic [LINE_W-1:0] in_line_data = '0;
    logic in_ready, quiesced, full, empty, mem_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic [LINE_W-1:0] mem_data;
    logic [LINE_BYTES-1:0] mem_be;

    int checks = 0, errors = 0;
    logic [ADDR_W-1:0] log_addr [64];
    logic [LINE_W-1:0] log_data [64];
    logic [LINE_BYTES-1:0] log_be [64];
    int log_n = 0;

    always #5 clk = ~clk;

    coalesce_wbuf uut (.*);

    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready && log_n < 64) begin
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_data;
            log_be[log_n]   = mem_be;
            log_n++;
        end
    end

    task automatic chk(input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic ln, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] w,
                        input logic [BPW-1:0] s, input logic [LINE_W-1:0] d);
        @(posedge clk); #2;
        in_valid = 1; in_line = ln; in_addr = a; in_word = w; in_strb = s; in_line_data = d;
        #1;
        while (!in_ready) begin @(posedge clk); #3; end
        @(posedge clk); #2;
        in_valid = 0;
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, output logic rdy);
        @(posedge clk); #2;
        in_valid = 1; in_line = 0; in_addr = a; in_word = '0; in_strb = 4'hF;
        #1; rdy = in_ready;
        in_valid = 0;
    endtask

    task automatic release_all();
        @(posedge clk); #2; mem_ready = 1;
        repeat (12) @(posedge clk);
        #2; mem_ready = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 empty", LINE_W'(empty), 1);
        chk("R1 full", LINE_W'(full), 0);
        chk("R1 in_ready", LINE_W'(in_ready), 1);
        chk("R1 mem_valid", LINE_W'(mem_valid), 0);
        chk("R1 quiesced", LINE_W'(quiesced), 1);
    endtask

    task automatic t_word();
        int b;
        logic [ADDR_W-1:0] a0;
        b = log_n;
        push(0, 32'h1000_0044, 32'hDEAD_BEEF, 4'hF, '0);
        @(negedge clk);
        chk("R2 mem_valid", LINE_W'(mem_valid), 1);
        chk("R2 mem_addr", LINE_W'(mem_addr), 32'h1000_0040);
        chk("R2 mem_be", LINE_W'(mem_be), 32'h0000_00F0);
        chk("R2 word1 data", LINE_W'(mem_data[63:32]), 32'hDEAD_BEEF);
        a0 = mem_addr;
        repeat (3) @(negedge clk);
        chk("R9 held valid", LINE_W'(mem_valid), 1);
        chk("R9 held addr", LINE_W'(mem_addr), LINE_W'(a0));
        release_all();
        chk("R2 one write", LINE_W'(log_n - b), 1);
        chk("R2 empty after", LINE_W'(empty), 1);
    endtask

    task automatic t_line();
        logic [LINE_W-1:0] d;
        int b;
        for (int i = 0; i < LINE_WORDS; i++) d[32*i +: 32] = 32'h0101_0101 * (i + 1) + 32'h11;
        b = log_n;
        push(1, 32'h2000_0010, '0, '0, d);
        release_all();
        chk("R3 count", LINE_W'(log_n - b), 1);
        chk("R3 addr", LINE_W'(log_addr[b]), 32'h2000_0000);
        chk("R3 be", LINE_W'(log_be[b]), 32'hFFFF_FFFF);
        chk("R3 data", log_data[b], d);
    endtask

    task automatic t_merge_full();
        int b;
        logic r;
        b = log_n;
        push(0, 32'h100, 32'hA0A0_A0A0, 4'hF, '0);
        push(0, 32'h204, 32'h1111_1111, 4'hF, '0);
        push(0, 32'h20C, 32'h2222_3333, 4'h3, '0);
        push(0, 32'h300, 32'h3, 4'hF, '0);
        @(negedge clk);
        chk("R4 merge took no slot", LINE_W'(full), 0);
        push(0, 32'h400, 32'h4, 4'hF, '0);
        @(negedge clk);
        chk("R7 full", LINE_W'(full), 1);
        probe(32'h500, r);
        chk("R7 new block refused", LINE_W'(r), 0);
        probe(32'h208, r);
        chk("R7 mergeable accepted", LINE_W'(r), 1);
        probe(32'h104, r);
        chk("R5 head closed at full", LINE_W'(r), 0);
        release_all();
        chk("R6 count", LINE_W'(log_n - b), 4);
        chk("R6 order 0", LINE_W'(log_addr[b]),   32'h100);
        chk("R6 order 1", LINE_W'(log_addr[b+1]), 32'h200);
        chk("R6 order 2", LINE_W'(log_addr[b+2]), 32'h300);
        chk("R6 order 3", LINE_W'(log_addr[b+3]), 32'h400);
        chk("R4 merged be", LINE_W'(log_be[b+1]), 32'h0000_30F0);
        chk("R4 merged word1", LINE_W'(log_data[b+1][63:32]), 32'h1111_1111);
        chk("R4 merged word3", LINE_W'(log_data[b+1][111:96]), 16'h3333);
    endtask

    task automatic t_byte_override();
        int b;
        b = log_n;
        push(0, 32'h600, 32'h6, 4'hF, '0);
        push(0, 32'h700, 32'hAABB_CCDD, 4'hF, '0);
        push(0, 32'h700, 32'h0000_EE00, 4'h2, '0);
        release_all();
        chk("R4 override count", LINE_W'(log_n - b), 2);
        chk("R4 override be", LINE_W'(log_be[b+1]), 32'h0000_000F);
        chk("R4 override data", LINE_W'(log_data[b+1][31:0]), 32'hAABB_EEDD);
    endtask

    task automatic t_head();
        int b;
        b = log_n;
        push(0, 32'h800, 32'h1, 4'hF, '0);
        push(0, 32'h804, 32'h2, 4'hF, '0);
        release_all();
        chk("R5 two writes", LINE_W'(log_n - b), 2);
        chk("R5 first addr", LINE_W'(log_addr[b]), 32'h800);
        chk("R5 first be", LINE_W'(log_be[b]), 32'h0000_000F);
        chk("R5 second addr", LINE_W'(log_addr[b+1]), 32'h800);
        chk("R5 second be", LINE_W'(log_be[b+1]), 32'h0000_00F0);
    endtask

    task automatic t_drain();
        logic r;
        push(0, 32'h900, 32'h9, 4'hF, '0);
        push(0, 32'hA00, 32'hA, 4'hF, '0);
        @(posedge clk); #2; drain_req = 1;
        @(posedge clk); #2; drain_req = 0;
        @(negedge clk);
        chk("R8 quiesced low", LINE_W'(quiesced), 0);
        probe(32'hB00, r);
        chk("R8 input blocked", LINE_W'(r), 0);
        repeat (4) @(negedge clk);
        chk("R8 still low while pending", LINE_W'(quiesced), 0);
        release_all();
        chk("R8 quiesced after", LINE_W'(quiesced), 1);
        chk("R8 empty after", LINE_W'(empty), 1);
        probe(32'hB00, r);
        chk("R8 input reopened", LINE_W'(r), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2; rst = 0;
        t_reset();
        t_word();
        t_line();
        t_merge_full();
        t_byte_override();
        t_head();
        t_drain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule